// File: doc/BRIEF.md
# UART break reset detector

This block sits beside a UART receiver and watches the raw receive line for a break: the line held at logic low with no gap for longer than a programmable number of clock cycles. When that limit is passed it issues a system reset request as a single pulse of fixed length. While that pulse is active, and while the block itself is held in reset, a tristate control tells the pad ring to turn bidirectional pins into inputs and to float outputs.

The same block can also send a break toward the host to wake it. A rising edge on the send request holds the transmit line low for a programmable number of cycles. The line then returns to its idle high level. Baud-rate timing, character framing and flow control are handled elsewhere. The detector only measures how long the line stays low, and the transmit side only forces the line low.

Top module: `uart_break_guard`

## Requirements
- R1: While `rst_n` is low, `sys_rst_o` and `tx_brk_o` are 0 and `io_tristate_o` is 1. After `rst_n` rises, `io_tristate_o` stays 1 until the second rising clock edge has passed.
- R2: `rx_i` is sampled on every rising edge through two flops. With a timeout T of 1 or more, T+1 consecutive low samples make `sys_rst_o` go to 1 on the second rising edge after the edge that took the last of those samples.
- R3: A low period of only T consecutive samples, followed by a high sample, produces no reset pulse.
- R4: A single high sample clears the low-duration count. Two low runs of T samples each, separated by one high sample, produce no reset pulse.
- R5: Each reset pulse holds `sys_rst_o` at 1 for exactly PULSE_LEN cycles (4 by default).
- R6: After a reset pulse, the detector does not fire again until at least one high sample has been taken. A low period of any length therefore produces at most one pulse. A new low period after a high sample can fire again.
- R7: A timeout value of 0 disables break-triggered reset, however long `rx_i` stays low.
- R8: `io_tristate_o` is 1 in every cycle in which `sys_rst_o` is 1, and is 0 otherwise once reset has been released.
- R9: A 0-to-1 change of `send_brk_i`, seen on a rising edge while no break is being sent, sets `tx_brk_o` to 1 (meaning TX is driven low) from that edge. It holds for exactly `brk_len_i` cycles and then returns to 0 (TX idle high).
- R10: The following do not start a break: a request that is held high (only its rising edge counts), a rising edge that arrives while a break is being sent, and a request made while `brk_len_i` is 0. In each case `tx_brk_o` keeps the value the running break, or idle, gives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rx_i | input | 1 | Raw UART receive line, idle high |
| brk_timeout_i | input | TMO_W | Timeout T in cycles. The low period must exceed T; 0 disables detection |
| send_brk_i | input | 1 | Break transmit request; acts on its rising edge |
| brk_len_i | input | BRK_W | Length of the transmitted break in cycles |
| sys_rst_o | output | 1 | System reset request pulse |
| tx_brk_o | output | 1 | 1 = force the TX pad low (break being sent) |
| io_tristate_o | output | 1 | 1 = bidirectional pins become inputs and outputs float |

## Verification
The bench aims at the exact boundary of the timeout. A low run one sample shorter than required, or a run broken by a single high sample, must not fire. A comparator that is off by one, or a counter that is not cleared by a high sample, would raise a spurious reset. It holds the line low for long stretches to catch a detector that re-fires while no high sample has been taken, or one that fires with a timeout of 0. On the transmit side it holds the request high, issues requests during a running break and uses a zero length. A design that acted on the level of the request, restarted a break in progress or sent a zero-length break would show a wrong `tx_brk_o` width or extra breaks.

// File: rtl/ubrk_pkg.sv
package ubrk_pkg;
  typedef enum logic {
    LINE_LOW  = 1'b0,
    LINE_IDLE = 1'b1
  } line_e;
endpackage

// File: rtl/ubrk_rst_sync.sv
module ubrk_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stg_q;
  logic [1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= 2'b00;
    else         stg_q <= stg_d;
  end

  assign rst_n_o = stg_q[1];
endmodule

// File: rtl/ubrk_rx_sync.sv
module ubrk_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic rx_o
);
  import ubrk_pkg::*;

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = rx_i;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], rx_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{LINE_IDLE}};
    else        chain_q <= chain_d;
  end

  assign rx_o = chain_q[STAGES-1];
endmodule

// File: rtl/ubrk_detect.sv
module ubrk_detect #(
  parameter int TMO_W     = 16,
  parameter int PULSE_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_s,
  input  logic [TMO_W-1:0] timeout_i,
  output logic             pulse_o
);
  import ubrk_pkg::*;

  localparam int                PCW     = $clog2(PULSE_LEN + 1);
  localparam logic [TMO_W-1:0]  CNT_MAX = '1;
  localparam logic [PCW-1:0]    PLOAD   = PCW'(PULSE_LEN);

  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic [PCW-1:0]   pcnt_q, pcnt_d;
  logic             armed_q, armed_d;
  logic             line_low, trig;

  always_comb begin
    line_low = (rx_s == LINE_LOW);
    trig     = armed_q && line_low && (timeout_i != '0) && (cnt_q >= timeout_i);

    cnt_d = cnt_q;
    if (!line_low)              cnt_d = '0;
    else if (cnt_q != CNT_MAX)  cnt_d = cnt_q + 1'b1;

    armed_d = armed_q;
    if (trig)           armed_d = 1'b0;
    else if (!line_low) armed_d = 1'b1;

    pcnt_d = pcnt_q;
    if (trig)               pcnt_d = PLOAD;
    else if (pcnt_q != '0)  pcnt_d = pcnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
      pcnt_q  <= '0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      pcnt_q  <= pcnt_d;
    end
  end

  assign pulse_o = (pcnt_q != '0);

  // R2: a new pulse only follows a low synchronized sample
  assert_pulse_after_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(rx_s) == LINE_LOW);

  // R6: while disarmed and the line stays low, no new pulse starts
  assert_no_rearm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && rx_s == LINE_LOW && !pulse_o) |=> !pulse_o);

  // R7: zero timeout never launches a pulse
  assert_zero_disables_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_i == '0 && !pulse_o) |=> !pulse_o);
endmodule

// File: rtl/ubrk_tx_gen.sv
module ubrk_tx_gen #(
  parameter int BRK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [BRK_W-1:0] len_i,
  output logic             hold_low_o
);
  logic [BRK_W-1:0] cnt_q, cnt_d;
  logic             req_q, req_d;
  logic             start;

  always_comb begin
    start = req_i && !req_q && (cnt_q == '0) && (len_i != '0);
    req_d = req_i;
    cnt_d = cnt_q;
    if (start)              cnt_d = len_i;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign hold_low_o = (cnt_q != '0);

  // R9: a break begins only after a request was seen
  assert_start_on_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_low_o) |-> $past(req_i));

  // R10: a running break counts down undisturbed by new requests
  assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/uart_break_guard.sv
module uart_break_guard #(
  parameter int TMO_W     = 16,
  parameter int BRK_W     = 8,
  parameter int PULSE_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic [TMO_W-1:0] brk_timeout_i,
  input  logic             send_brk_i,
  input  logic [BRK_W-1:0] brk_len_i,
  output logic             sys_rst_o,
  output logic             tx_brk_o,
  output logic             io_tristate_o
);
  logic rst_n_s;
  logic rx_s;

  ubrk_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  ubrk_rx_sync #(.STAGES(2)) u_rx (
    .clk   (clk),
    .rst_n (rst_n_s),
    .rx_i  (rx_i),
    .rx_o  (rx_s)
  );

  ubrk_detect #(.TMO_W(TMO_W), .PULSE_LEN(PULSE_LEN)) u_det (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .rx_s      (rx_s),
    .timeout_i (brk_timeout_i),
    .pulse_o   (sys_rst_o)
  );

  ubrk_tx_gen #(.BRK_W(BRK_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .req_i      (send_brk_i),
    .len_i      (brk_len_i),
    .hold_low_o (tx_brk_o)
  );

  assign io_tristate_o = !rst_n_s || sys_rst_o;

  // R8: pins float whenever a reset request is active
  assert_float_in_reset_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    sys_rst_o |-> io_tristate_o);
endmodule

// File: tb/tb_uart_break_guard.sv
module tb_uart_break_guard;
  localparam int TMO_W = 16;
  localparam int BRK_W = 8;
  localparam int PLEN  = 4;
  localparam int CMAX  = (1 << TMO_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             rx_i;
  logic [TMO_W-1:0] brk_timeout_i;
  logic             send_brk_i;
  logic [BRK_W-1:0] brk_len_i;
  logic             sys_rst_o, tx_brk_o, io_tristate_o;

  int checks = 0;
  int fails  = 0;
  string tag = "R1";
  int rise_cnt, hi_cnt, tx_rise, tx_hi;
  logic prev_rst, prev_tx;

  // reference state
  logic m_rs1, m_rs2, m_q1, m_q2, m_armed, m_req;
  int   m_cnt, m_pcnt, m_txcnt;

  uart_break_guard #(.TMO_W(TMO_W), .BRK_W(BRK_W), .PULSE_LEN(PLEN)) dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .brk_timeout_i(brk_timeout_i),
    .send_brk_i(send_brk_i), .brk_len_i(brk_len_i),
    .sys_rst_o(sys_rst_o), .tx_brk_o(tx_brk_o), .io_tristate_o(io_tristate_o)
  );

  always #10 clk = ~clk;

  task automatic model_reset();
    m_rs1 = 0; m_rs2 = 0; m_q1 = 1; m_q2 = 1; m_armed = 1; m_req = 0;
    m_cnt = 0; m_pcnt = 0; m_txcnt = 0;
  endtask

  task automatic model_step();
    logic trig, start;
    if (!rst_n) begin
      model_reset();
      return;
    end
    if (m_rs2) begin
      trig  = m_armed && !m_q2 && (brk_timeout_i != 0) && (m_cnt >= int'(brk_timeout_i));
      start = send_brk_i && !m_req && (m_txcnt == 0) && (brk_len_i != 0);
      if (trig) m_armed = 0; else if (m_q2) m_armed = 1;
      if (m_q2) m_cnt = 0; else if (m_cnt < CMAX) m_cnt = m_cnt + 1;
      if (trig) m_pcnt = PLEN; else if (m_pcnt != 0) m_pcnt = m_pcnt - 1;
      m_q2 = m_q1; m_q1 = rx_i;
      m_req = send_brk_i;
      if (start) m_txcnt = int'(brk_len_i); else if (m_txcnt != 0) m_txcnt = m_txcnt - 1;
    end
    m_rs2 = m_rs1; m_rs1 = 1;
  endtask

  task automatic check1(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_int(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // called at a negedge: inputs already set
  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    check1("sys_rst_o", sys_rst_o, m_pcnt != 0);
    check1("tx_brk_o", tx_brk_o, m_txcnt != 0);
    check1("io_tristate_o", io_tristate_o, !m_rs2 || (m_pcnt != 0));
    if (sys_rst_o && !prev_rst) rise_cnt++;
    if (sys_rst_o) hi_cnt++;
    if (tx_brk_o && !prev_tx) tx_rise++;
    if (tx_brk_o) tx_hi++;
    prev_rst = sys_rst_o;
    prev_tx  = tx_brk_o;
  endtask

  task automatic run(logic rx, int n);
    for (int i = 0; i < n; i++) begin
      rx_i = rx;
      tick();
    end
  endtask

  task automatic clr();
    rise_cnt = 0; hi_cnt = 0; tx_rise = 0; tx_hi = 0;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    prev_rst = 0; prev_tx = 0;
    rst_n = 0; rx_i = 1; send_brk_i = 0; brk_len_i = 3; brk_timeout_i = 5;
    model_reset();
    @(negedge clk);
    tag = "R1";
    run(1'b1, 3);
    rst_n = 1;
    run(1'b1, 5);

    tag = "R2"; brk_timeout_i = 3; clr();
    run(1'b0, 4); run(1'b1, 10);
    check_int("pulses after T+1 low samples", rise_cnt, 1);

    tag = "R3"; clr();
    run(1'b0, 3); run(1'b1, 10);
    check_int("pulses after T low samples", rise_cnt, 0);

    tag = "R4"; clr();
    run(1'b0, 3); run(1'b1, 1); run(1'b0, 3); run(1'b1, 10);
    check_int("pulses with one-sample gap", rise_cnt, 0);

    tag = "R5"; brk_timeout_i = 2; clr();
    run(1'b0, 6); run(1'b1, 10);
    check_int("pulse width", hi_cnt, PLEN);

    tag = "R6"; clr();
    run(1'b0, 60);
    check_int("pulses over long low", rise_cnt, 1);
    run(1'b1, 2); run(1'b0, 10); run(1'b1, 10);
    check_int("pulses after rearm", rise_cnt, 2);

    tag = "R7"; brk_timeout_i = 0; clr();
    run(1'b0, 80); run(1'b1, 5);
    check_int("pulses with zero timeout", rise_cnt, 0);

    tag = "R8"; brk_timeout_i = 1; clr();
    run(1'b0, 8); run(1'b1, 8);
    check_int("tristate pulse seen", hi_cnt, PLEN);

    tag = "R9"; brk_len_i = 5; clr();
    send_brk_i = 1; run(1'b1, 1); send_brk_i = 0; run(1'b1, 12);
    check_int("break width", tx_hi, 5);

    tag = "R10"; brk_len_i = 3; clr();
    send_brk_i = 1; run(1'b1, 20); send_brk_i = 0; run(1'b1, 3);
    check_int("breaks from held request", tx_rise, 1);
    clr(); brk_len_i = 6;
    send_brk_i = 1; run(1'b1, 1); send_brk_i = 0; run(1'b1, 1);
    send_brk_i = 1; run(1'b1, 1); send_brk_i = 0; run(1'b1, 10);
    check_int("breaks with request while busy", tx_rise, 1);
    check_int("busy break width", tx_hi, 6);
    clr(); brk_len_i = 0;
    send_brk_i = 1; run(1'b1, 1); send_brk_i = 0; run(1'b1, 5);
    check_int("breaks with zero length", tx_rise, 0);

    tag = "R2";
    for (int r = 0; r < 300; r++) begin
      brk_timeout_i = TMO_W'($urandom_range(0, 7));
      brk_len_i     = BRK_W'($urandom_range(0, 6));
      run(1'b1, $urandom_range(1, 4));
      for (int s = 0; s < 3; s++) begin
        send_brk_i = 1'($urandom_range(0, 1));
        rx_i = 1'($urandom_range(0, 1));
        tick();
        send_brk_i = 0;
        run(1'b0, $urandom_range(0, 10));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule